// File: doc/BRIEF.md
# Serial Programming Command and Data Slave

This block is the device-side end of a two-wire programming link. An external host drives a slow programming clock and a data pin. The block samples both with the fast system clock, assembles 6-bit commands, and answers the load and read commands with a 16-slot data frame. Increment, begin-program and bulk-erase commands leave as one-cycle pulses. A finished load leaves as a word on a valid/ready output stream. For a read, the block fetches one word from an external memory port over a valid/ready request and shifts it onto the data pin while it holds the pin's output enable.

The host paces every transfer and cannot be stalled. The block therefore takes no back-pressure on the link itself. Back-pressure applies only at the load stream. The word stays put until `ld_ready` is seen high, and a later load that completes first replaces it. The read port must answer before the second rising programming-clock edge of the read frame. If it does not, zeros are sent. A level input, `mode_en`, frames a programming session. While it is low, all command and frame state is held cleared.

Top module: `pgm_serial_slave`

## Requirements
- R1: A command is six data-pin bits sampled on six falling programming-clock edges, first bit = code bit 0; it is acted on after the sixth falling edge, and each command pulse lasts one system clock.
- R2: Codes written bit5..bit0 without a data frame: 000110 gives `inc_pulse`, 001001 gives `bulk_prog_pulse`, 001011 gives `bulk_data_pulse`, 001000 gives `prog_pulse`.
- R3: Codes 000000, 000010 and 000011 open a load frame of 16 falling edges; falls 2 to 15 carry word bits 0 to 13; after the 16th fall `ld_valid` rises with `ld_target` 0, 1 or 2 respectively.
- R4: For a data-memory load (target 2) only word bits 7..0 are kept; `ld_word` bits 13..8 read zero.
- R5: Codes 000100 and 000101 open a read frame: `pdat_oe` is high from the 2nd through the 15th rising edge, bit k is driven from rising edge k+2, and the pin is released at the 16th rising edge.
- R6: A read code raises `rd_req` with `rd_space` 0 (program) or 1 (data); it drops after the cycle with `rd_valid` high; for data space only bits 7..0 of `rd_data` are sent and bits 8..13 go out as zero.
- R7: Any other code is ignored: no pulse, no frame, and the next six falling edges form a new command.
- R8: `ld_valid` with `ld_ready` low holds `ld_word` and `ld_target` unchanged until a newer load completes; the cycle after `ld_valid && ld_ready` it is low.
- R9: While `mode_en` is low a partial command or frame is discarded and `pdat_oe`, `ld_valid`, `rd_req` are low the following cycle.
- R10: With `DECODE_MODE`=1 only code bits 3..0 select the command, except that 001000 is begin with `prog_erase`=1, 011000 is begin with `prog_erase`=0, and other upper patterns with low bits 1000 are ignored.
- R11: Any number of system clocks, at least three, may separate programming-clock edges, commands and frames.
- R12: With `DECODE_MODE`=0 every `prog_pulse` carries `prog_erase`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Programming session active; low clears frame state |
| pclk_in | input | 1 | Programming clock from host (asynchronous) |
| pdat_in | input | 1 | Data pin input value |
| pdat_out | output | 1 | Data pin output value |
| pdat_oe | output | 1 | Data pin output enable |
| inc_pulse | output | 1 | Increment-address command |
| prog_pulse | output | 1 | Begin-programming command |
| prog_erase | output | 1 | Erase-before-write flag, valid with `prog_pulse` |
| bulk_prog_pulse | output | 1 | Bulk-erase program memory command |
| bulk_data_pulse | output | 1 | Bulk-erase data memory command |
| ld_valid | output | 1 | Load word available |
| ld_ready | input | 1 | Consumer accepts the load word |
| ld_word | output | 14 | Loaded word |
| ld_target | output | 2 | 0 configuration, 1 program, 2 data memory |
| rd_req | output | 1 | Read word requested |
| rd_space | output | 1 | 0 program space, 1 data space |
| rd_valid | input | 1 | Read word present on `rd_data` |
| rd_data | input | 14 | Read word |

## Verification
The hardest state to reach is a session cut off in the middle of a command or a read frame while the pin is being driven. Afterwards, an intact command must decode with no leftover bits. The bench shifts three bits of a command, or four cycles of a read frame, drops `mode_en`, then sends a full increment and counts exactly one pulse. A second instance built with the narrow decoder gets the same pin stimulus. Upper-bit codes that the wide decoder rejects are then shown to be taken by the narrow one.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  localparam int CMD_W = 6;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_LD_CFG, CMD_LD_PRG, CMD_LD_DAT, CMD_RD_PRG, CMD_RD_DAT,
    CMD_INC, CMD_BEG_EP, CMD_BEG_PO, CMD_BLK_PRG, CMD_BLK_DAT
  } cmd_e;

  typedef enum logic [1:0] {
    TGT_CFG = 2'd0,
    TGT_PRG = 2'd1,
    TGT_DAT = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_LOAD,
    PH_READ
  } phase_e;
endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES < 2) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) q <= '0;
        else        q <= d;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] st;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st <= '0;
        else        st <= {st[STAGES-2:0], d};
      assign q = st[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pgm_cmd_decode.sv
module pgm_cmd_decode #(
  parameter int DECODE_MODE = 0
) (
  input  logic [pgm_pkg::CMD_W-1:0] code,
  output pgm_pkg::cmd_e             cmd
);
  import pgm_pkg::*;

  generate
    if (DECODE_MODE == 0) begin : g_full
      always_comb begin
        case (code)
          6'b000000: cmd = CMD_LD_CFG;
          6'b000010: cmd = CMD_LD_PRG;
          6'b000011: cmd = CMD_LD_DAT;
          6'b000100: cmd = CMD_RD_PRG;
          6'b000101: cmd = CMD_RD_DAT;
          6'b000110: cmd = CMD_INC;
          6'b001000: cmd = CMD_BEG_EP;
          6'b001001: cmd = CMD_BLK_PRG;
          6'b001011: cmd = CMD_BLK_DAT;
          default:   cmd = CMD_NONE;
        endcase
      end
    end else begin : g_low4
      always_comb begin
        cmd = CMD_NONE;
        case (code[3:0])
          4'b0000: cmd = CMD_LD_CFG;
          4'b0010: cmd = CMD_LD_PRG;
          4'b0011: cmd = CMD_LD_DAT;
          4'b0100: cmd = CMD_RD_PRG;
          4'b0101: cmd = CMD_RD_DAT;
          4'b0110: cmd = CMD_INC;
          4'b1001: cmd = CMD_BLK_PRG;
          4'b1011: cmd = CMD_BLK_DAT;
          4'b1000: begin
            if (code[5:4] == 2'b00)      cmd = CMD_BEG_EP;
            else if (code[5:4] == 2'b01) cmd = CMD_BEG_PO;
          end
          default: cmd = CMD_NONE;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/pgm_rd_port.sv
module pgm_rd_port #(
  parameter int WORD_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              start_data,
  output logic              rd_req,
  output logic              rd_space,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - DATA_W;

  logic [WORD_W-1:0] masked;
  assign masked = rd_space ? {{PAD_W{1'b0}}, rd_data[DATA_W-1:0]} : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req   <= 1'b0;
      rd_space <= 1'b0;
      word     <= '0;
    end else if (clr) begin
      rd_req   <= 1'b0;
      word     <= '0;
    end else if (start) begin
      rd_req   <= 1'b1;
      rd_space <= start_data;
      word     <= '0;
    end else if (rd_req && rd_valid) begin
      rd_req   <= 1'b0;
      word     <= masked;
    end
  end
endmodule

// File: rtl/pgm_serial_slave.sv
module pgm_serial_slave #(
  parameter int WORD_W      = 14,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DECODE_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              pclk_in,
  input  logic              pdat_in,
  output logic              pdat_out,
  output logic              pdat_oe,
  output logic              inc_pulse,
  output logic              prog_pulse,
  output logic              prog_erase,
  output logic              bulk_prog_pulse,
  output logic              bulk_data_pulse,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [WORD_W-1:0] ld_word,
  output logic [1:0]        ld_target,
  output logic              rd_req,
  output logic              rd_space,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data
);
  import pgm_pkg::*;

  localparam int FRAME_LEN = WORD_W + 2;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int CC_W      = $clog2(CMD_W);
  localparam int PAD_W     = WORD_W - DATA_W;
  localparam logic [CNT_W-1:0] FL_LAST  = CNT_W'(FRAME_LEN);
  localparam logic [CC_W-1:0]  CMD_LAST = CC_W'(CMD_W - 1);

  // Synchronised pin samples and edge detection
  logic clk_s, dat_s, clk_q, rise, fall;

  pgm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pdat_in, pclk_in}),
    .q    ({dat_s, clk_s})
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= clk_s;

  assign rise = clk_s & ~clk_q;
  assign fall = ~clk_s & clk_q;

  // Frame state
  phase_e            phase;
  logic [CMD_W-2:0]  cbits;
  logic [CC_W-1:0]   ccnt;
  logic [CNT_W-1:0]  fall_cnt, rise_cnt, fall_nxt, rise_nxt;
  logic [WORD_W-1:0] lsh, rword, ld_word_q;
  tgt_e              pend_tgt, ld_tgt_q;
  logic              oe_q, dout_q;

  logic [CMD_W-1:0]  code_next;
  cmd_e              cmd_now;
  logic              cmd_done, rd_start, in_read, read_end, load_end;

  assign code_next = {dat_s, cbits};
  assign fall_nxt  = fall_cnt + CNT_W'(1);
  assign rise_nxt  = rise_cnt + CNT_W'(1);
  assign in_read   = (phase == PH_READ);
  assign cmd_done  = mode_en && (phase == PH_CMD) && fall && (ccnt == CMD_LAST);
  assign rd_start  = cmd_done && ((cmd_now == CMD_RD_PRG) || (cmd_now == CMD_RD_DAT));
  assign read_end  = in_read && fall && (fall_nxt == FL_LAST);
  assign load_end  = mode_en && (phase == PH_LOAD) && fall && (fall_nxt == FL_LAST);

  pgm_cmd_decode #(.DECODE_MODE(DECODE_MODE)) u_dec (
    .code(code_next),
    .cmd (cmd_now)
  );

  pgm_rd_port #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!mode_en || read_end),
    .start     (rd_start),
    .start_data(cmd_now == CMD_RD_DAT),
    .rd_req    (rd_req),
    .rd_space  (rd_space),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .word      (rword)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase           <= PH_CMD;
      cbits           <= '0;
      ccnt            <= '0;
      fall_cnt        <= '0;
      rise_cnt        <= '0;
      lsh             <= '0;
      pend_tgt        <= TGT_CFG;
      ld_tgt_q        <= TGT_CFG;
      ld_word_q       <= '0;
      ld_valid        <= 1'b0;
      oe_q            <= 1'b0;
      dout_q          <= 1'b0;
      inc_pulse       <= 1'b0;
      prog_pulse      <= 1'b0;
      prog_erase      <= 1'b0;
      bulk_prog_pulse <= 1'b0;
      bulk_data_pulse <= 1'b0;
    end else begin
      inc_pulse       <= 1'b0;
      prog_pulse      <= 1'b0;
      bulk_prog_pulse <= 1'b0;
      bulk_data_pulse <= 1'b0;
      if (ld_valid && ld_ready) ld_valid <= 1'b0;

      if (!mode_en) begin
        phase    <= PH_CMD;
        cbits    <= '0;
        ccnt     <= '0;
        fall_cnt <= '0;
        rise_cnt <= '0;
        oe_q     <= 1'b0;
        dout_q   <= 1'b0;
        ld_valid <= 1'b0;
      end else begin
        case (phase)
          PH_CMD: begin
            if (fall) begin
              if (ccnt == CMD_LAST) begin
                ccnt  <= '0;
                cbits <= '0;
                case (cmd_now)
                  CMD_LD_CFG:  begin phase <= PH_LOAD; pend_tgt <= TGT_CFG; end
                  CMD_LD_PRG:  begin phase <= PH_LOAD; pend_tgt <= TGT_PRG; end
                  CMD_LD_DAT:  begin phase <= PH_LOAD; pend_tgt <= TGT_DAT; end
                  CMD_RD_PRG,
                  CMD_RD_DAT:  phase <= PH_READ;
                  CMD_INC:     inc_pulse <= 1'b1;
                  CMD_BEG_EP:  begin prog_pulse <= 1'b1; prog_erase <= 1'b1; end
                  CMD_BEG_PO:  begin prog_pulse <= 1'b1; prog_erase <= 1'b0; end
                  CMD_BLK_PRG: bulk_prog_pulse <= 1'b1;
                  CMD_BLK_DAT: bulk_data_pulse <= 1'b1;
                  default:     ;
                endcase
              end else begin
                ccnt  <= ccnt + CC_W'(1);
                cbits <= code_next[CMD_W-1:1];
              end
            end
          end
          PH_LOAD: begin
            if (fall) begin
              fall_cnt <= fall_nxt;
              for (int i = 0; i < WORD_W; i++)
                if (fall_nxt == CNT_W'(i + 2)) lsh[i] <= dat_s;
              if (fall_nxt == FL_LAST) begin
                phase     <= PH_CMD;
                fall_cnt  <= '0;
                ld_valid  <= 1'b1;
                ld_tgt_q  <= pend_tgt;
                ld_word_q <= (pend_tgt == TGT_DAT) ?
                             {{PAD_W{1'b0}}, lsh[DATA_W-1:0]} : lsh;
              end
            end
          end
          PH_READ: begin
            if (rise) begin
              rise_cnt <= rise_nxt;
              if (rise_nxt == FL_LAST) begin
                oe_q <= 1'b0;
              end else if (rise_nxt >= CNT_W'(2)) begin
                oe_q <= 1'b1;
                for (int i = 0; i < WORD_W; i++)
                  if (rise_nxt == CNT_W'(i + 2)) dout_q <= rword[i];
              end
            end
            if (fall) begin
              fall_cnt <= fall_nxt;
              if (fall_nxt == FL_LAST) begin
                phase    <= PH_CMD;
                fall_cnt <= '0;
                rise_cnt <= '0;
                oe_q     <= 1'b0;
                dout_q   <= 1'b0;
              end
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  assign pdat_out  = dout_q;
  assign pdat_oe   = oe_q;
  assign ld_word   = ld_word_q;
  assign ld_target = ld_tgt_q;
endmodule

// File: rtl/pgm_serial_slave_chk.sv
module pgm_serial_slave_chk #(
  parameter int WORD_W      = 14,
  parameter int DATA_W      = 8,
  parameter int DECODE_MODE = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_en,
  input logic              pdat_oe,
  input logic              in_read,
  input logic              load_end,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [WORD_W-1:0] ld_word,
  input logic [1:0]        ld_target,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              prog_pulse,
  input logic              prog_erase
);
  p_oe_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pdat_oe |-> in_read);

  p_ld_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && ld_valid && !ld_ready && !load_end) |=>
      (ld_valid && $stable(ld_word) && $stable(ld_target)));

  p_ld_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !load_end) |=> !ld_valid);

  p_dat_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_target == 2'd2) |-> (ld_word[WORD_W-1:DATA_W] == '0));

  p_rd_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> !rd_req);

  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (!pdat_oe && !ld_valid && !rd_req));

  p_full_erase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (DECODE_MODE == 0 && prog_pulse) |-> prog_erase);
endmodule

bind pgm_serial_slave pgm_serial_slave_chk #(
  .WORD_W(WORD_W), .DATA_W(DATA_W), .DECODE_MODE(DECODE_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .pdat_oe(pdat_oe),
  .in_read(in_read), .load_end(load_end), .ld_valid(ld_valid),
  .ld_ready(ld_ready), .ld_word(ld_word), .ld_target(ld_target),
  .rd_req(rd_req), .rd_valid(rd_valid), .prog_pulse(prog_pulse),
  .prog_erase(prog_erase)
);

// File: tb/sim_pgm_serial_slave.sv
`timescale 1ns/1ps
module sim_pgm_serial_slave;
  localparam logic [13:0] MEM_P = 14'h2A5C;
  localparam logic [13:0] MEM_D = 14'h3FA5;
  localparam int NV = 11;
  // {code[5:0], data[13:0], event[3:0], half[3:0]}
  // event: 0 none,1 inc,2 prog,3 bulk prog,4 bulk data,5 ld cfg,6 ld prog,7 ld data,8 rd prog,9 rd data
  localparam logic [27:0] VEC [NV] = '{
    {6'b000010, 14'h1ABC, 4'd6, 4'd4},
    {6'b000000, 14'h2001, 4'd5, 4'd5},
    {6'b000011, 14'h3F5A, 4'd7, 4'd6},
    {6'b000110, 14'h0000, 4'd1, 4'd4},
    {6'b001000, 14'h0000, 4'd2, 4'd7},
    {6'b001001, 14'h0000, 4'd3, 4'd4},
    {6'b001011, 14'h0000, 4'd4, 4'd5},
    {6'b000100, 14'h0000, 4'd8, 4'd4},
    {6'b000101, 14'h0000, 4'd9, 4'd6},
    {6'b000111, 14'h0000, 4'd0, 4'd4},
    {6'b111111, 14'h0000, 4'd0, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0, mode_en = 1'b0, pclk = 1'b0, pdat = 1'b0;
  logic ld_ready = 1'b1, rd_valid = 1'b0;
  logic [13:0] rd_data = '0;
  logic dout, oe, inc_p, prog_p, prog_e, bp_p, bd_p, ld_valid, rd_req, rd_space;
  logic [13:0] ld_word;
  logic [1:0]  ld_target;
  logic d1_out, d1_oe, i1, p1, e1, b1, b2, lv1, rq1, rs1;
  logic [13:0] lw1;
  logic [1:0]  lt1;

  int n_chk = 0, n_fail = 0;
  int n_inc = 0, n_prog = 0, n_prog_er = 0, n_bp = 0, n_bd = 0, n_ld = 0;
  int n1_inc = 0, n1_prog = 0, n1_prog_er = 0;
  logic [13:0] last_word = '0;
  logic [1:0]  last_tgt = '0;
  logic        last_space = 1'b0;

  always #2 clk = ~clk;

  pgm_serial_slave u0 (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .pclk_in(pclk), .pdat_in(pdat),
    .pdat_out(dout), .pdat_oe(oe), .inc_pulse(inc_p), .prog_pulse(prog_p),
    .prog_erase(prog_e), .bulk_prog_pulse(bp_p), .bulk_data_pulse(bd_p),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_word(ld_word), .ld_target(ld_target),
    .rd_req(rd_req), .rd_space(rd_space), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  pgm_serial_slave #(.DECODE_MODE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .pclk_in(pclk), .pdat_in(pdat),
    .pdat_out(d1_out), .pdat_oe(d1_oe), .inc_pulse(i1), .prog_pulse(p1),
    .prog_erase(e1), .bulk_prog_pulse(b1), .bulk_data_pulse(b2),
    .ld_valid(lv1), .ld_ready(1'b1), .ld_word(lw1), .ld_target(lt1),
    .rd_req(rq1), .rd_space(rs1), .rd_valid(1'b1), .rd_data(14'h0000)
  );

  // Event monitor
  always @(posedge clk) begin
    if (inc_p) n_inc++;
    if (prog_p) n_prog++;
    if (prog_p && prog_e) n_prog_er++;
    if (bp_p) n_bp++;
    if (bd_p) n_bd++;
    if (ld_valid && ld_ready) begin n_ld++; last_word = ld_word; last_tgt = ld_target; end
    if (rd_req && rd_valid) last_space = rd_space;
    if (i1) n1_inc++;
    if (p1) n1_prog++;
    if (p1 && e1) n1_prog_er++;
  end

  // Memory read port model
  always @(negedge clk) begin
    rd_valid <= rd_req && !rd_valid;
    rd_data  <= rd_space ? MEM_D : MEM_P;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, input int h);
    pclk = 1'b1; pdat = b; wait_clks(h);
    pclk = 1'b0; wait_clks(h);
  endtask

  task automatic send_cmd(input logic [5:0] c, input int h);
    for (int i = 0; i < 6; i++) bit_cycle(c[i], h);
    pdat = 1'b0;
    wait_clks(h);
  endtask

  task automatic send_load(input logic [13:0] w, input int h);
    bit_cycle(1'b0, h);
    for (int i = 0; i < 14; i++) bit_cycle(w[i], h);
    bit_cycle(1'b0, h);
    pdat = 1'b0;
    wait_clks(h);
  endtask

  task automatic do_read(input int h, output logic [13:0] got, output bit oe_ok);
    got = '0; oe_ok = 1'b1;
    pdat = 1'b0;
    for (int c = 1; c <= 16; c++) begin
      pclk = 1'b1; wait_clks(h);
      if (oe !== ((c >= 2) && (c <= 15))) oe_ok = 1'b0;
      if (c >= 2 && c <= 15) got[c-2] = dout;
      pclk = 1'b0; wait_clks(h);
    end
    wait_clks(h);
    if (oe !== 1'b0) oe_ok = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [13:0] got;
    bit ok_oe;
    int s_inc, s_prog, s_er, s_bp, s_bd, s_ld, s1_inc, s1_prog, s1_er;

    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(3);
    mode_en = 1'b1;
    wait_clks(3);
    // Reset state (R9)
    check(!oe && !ld_valid && !rd_req, "R9 reset outputs", {oe, ld_valid, rd_req}, 0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [5:0]  code;
      logic [13:0] dat;
      logic [3:0]  ev;
      int h;
      {code, dat, ev} = VEC[v][27:4];
      h = int'(VEC[v][3:0]);
      s_inc = n_inc; s_prog = n_prog; s_er = n_prog_er; s_bp = n_bp; s_bd = n_bd; s_ld = n_ld;
      s1_er = n1_prog_er;
      send_cmd(code, h);
      if (ev >= 4'd5 && ev <= 4'd7) send_load(dat, h);
      if (ev == 4'd8 || ev == 4'd9) begin
        do_read(h, got, ok_oe);
        check(ok_oe, "R5 output enable window", v, 1);
        check(got == ((ev == 4'd9) ? (MEM_D & 14'h00FF) : MEM_P), "R6 read word",
              got, (ev == 4'd9) ? (MEM_D & 14'h00FF) : MEM_P);
        check(last_space == (ev == 4'd9), "R6 read space", last_space, ev == 4'd9);
      end
      wait_clks(8 + 3 * v);   // gaps of varying length (R11)
      check({n_inc - s_inc, n_prog - s_prog, n_bp - s_bp, n_bd - s_bd, n_ld - s_ld} ==
            {32'(ev == 4'd1), 32'(ev == 4'd2), 32'(ev == 4'd3), 32'(ev == 4'd4),
             32'(ev >= 4'd5 && ev <= 4'd7)},
            "R2 R3 R7 event counts", v, ev);
      if (ev == 4'd2) begin
        check(n_prog_er - s_er == 1, "R12 begin with erase", n_prog_er - s_er, 1);
        check(n1_prog_er - s1_er == 1, "R10 narrow decode erase begin", n1_prog_er - s1_er, 1);
      end
      if (ev >= 4'd5 && ev <= 4'd7) begin
        check(last_word == ((ev == 4'd7) ? (dat & 14'h00FF) : dat), "R3 R4 load word",
              last_word, (ev == 4'd7) ? (dat & 14'h00FF) : dat);
        check(last_tgt == 2'(ev - 4'd5), "R3 load target", last_tgt, ev - 4'd5);
      end
    end

    // R7: unknown code then increment; no frame is expected after the unknown code
    s_inc = n_inc; s_ld = n_ld;
    send_cmd(6'b000111, 4);
    send_cmd(6'b000110, 4);
    wait_clks(8);
    check(n_inc - s_inc == 1 && n_ld == s_ld && !rd_req, "R7 unknown ignored", n_inc - s_inc, 1);

    // R1: bit order, 011000 is not an increment/begin in full decode
    s_inc = n_inc; s_prog = n_prog;
    send_cmd(6'b011000, 4);
    wait_clks(8);
    check(n_prog == s_prog && n_inc == s_inc, "R1 bit order / full decode rejects 011000", n_prog - s_prog, 0);

    // R10: narrow decode
    check(n1_prog >= 1, "R10 narrow decode saw begin", n1_prog, 1);
    s1_prog = n1_prog; s1_er = n1_prog_er; s1_inc = n1_inc; s_inc = n_inc;
    send_cmd(6'b011000, 5);
    wait_clks(8);
    check(n1_prog - s1_prog == 1 && n1_prog_er == s1_er, "R10 program-only begin",
          n1_prog - s1_prog, 1);
    send_cmd(6'b110110, 5);
    wait_clks(8);
    check(n1_inc - s1_inc == 1 && n_inc == s_inc, "R10 upper bits ignored for increment",
          n1_inc - s1_inc, 1);

    // R9: session drop mid command
    s_inc = n_inc;
    bit_cycle(1'b0, 4); bit_cycle(1'b1, 4); bit_cycle(1'b1, 4);
    mode_en = 1'b0; wait_clks(4); mode_en = 1'b1; wait_clks(4);
    send_cmd(6'b000110, 4);
    wait_clks(8);
    check(n_inc - s_inc == 1, "R9 partial command discarded", n_inc - s_inc, 1);

    // R9: session drop mid read frame
    send_cmd(6'b000100, 4);
    for (int c = 1; c <= 4; c++) begin
      pclk = 1'b1; wait_clks(4); pclk = 1'b0; wait_clks(4);
    end
    pclk = 1'b1; wait_clks(4);
    check(oe === 1'b1, "R5 pin driven mid frame", oe, 1);
    pclk = 1'b0; wait_clks(2);
    mode_en = 1'b0; wait_clks(2);
    check(!oe && !rd_req, "R9 read frame aborted", {oe, rd_req}, 0);
    wait_clks(3); mode_en = 1'b1; wait_clks(4);
    s_inc = n_inc;
    send_cmd(6'b000110, 4);
    wait_clks(8);
    check(n_inc - s_inc == 1, "R9 framing restarts after abort", n_inc - s_inc, 1);

    // R8: back-pressure on the load stream
    ld_ready = 1'b0;
    s_ld = n_ld;
    send_cmd(6'b000010, 4);
    send_load(14'h0155, 4);
    wait_clks(30);
    check(ld_valid && ld_word == 14'h0155 && ld_target == 2'd1, "R8 word held",
          ld_word, 14'h0155);
    ld_ready = 1'b1;
    wait_clks(2);
    check(!ld_valid && n_ld - s_ld == 1 && last_word == 14'h0155, "R8 word taken once",
          n_ld - s_ld, 1);

    // R11: very long edge spacing
    s_inc = n_inc;
    send_cmd(6'b000110, 40);
    wait_clks(8);
    check(n_inc - s_inc == 1, "R11 slow clock accepted", n_inc - s_inc, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule